// File: doc/BRIEF.md
# Timestamped Change-Driven Sample Packer

The packer watches a 16-bit sampled input and stores it in compressed form to a word-wide memory write port. Nothing is written while the input holds still. When the input moves, the block opens a cluster of eight consecutive words. The first word is a 16-bit timestamp and the next seven are samples taken on consecutive clock ticks, the first of them on the timestamp tick. A free-running 16-bit tick counter supplies the timestamps. A cluster is also forced after a fixed number of quiet ticks, 65536 by default, so that a reader can always recover counter rollover.

Write addresses are linear word addresses, 24 bits by default. The upper 15 bits pick a memory row of 512 words, which holds 64 clusters. The lower 9 bits pick the word within that row. The pointer wraps from the last word back to word 0 and raises a sticky wrap flag. A run control gates the packing. Dropping it in the middle of a cluster still completes that cluster, with the remaining slots padded with the last captured sample.

Top module: `pk_sample_packer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), wr_en_o and wrapped_o are 0, the write address pointer is 0 and the tick counter is 0.
- R2: While run_i is low and no cluster is in progress, no word is written.
- R3: A cluster is exactly 8 writes on 8 consecutive cycles: a timestamp word, then 7 sample words. Sample word k (k = 0..6) is the value sample_i had at the k-th clock edge after the opening edge (k = 0 is the opening edge itself).
- R4: When idle with run_i high, a cluster opens at an edge where sample_i differs from the last sample word written. If the two are equal, nothing is written.
- R5: The timestamp word equals the tick counter at the opening edge. The counter counts every clock edge since reset, modulo 65536, and is zero-extended into the data word.
- R6: If no cluster has opened for FORCE_TICKS edges (default 65536) and run_i is high, a cluster opens anyway. With the default, its timestamp equals that of the previous cluster.
- R7: The first idle edge with run_i high that follows any edge with run_i low opens a cluster, whether or not the value changed.
- R8: If run_i drops during a cluster, the cluster still completes 8 words. Every remaining sample slot repeats the last sample captured while run_i was high.
- R9: Each write goes to the previous write address plus one, starting at 0 after reset. Address bits [23:9] are the row and bits [8:0] the word in the row, so every timestamp lands at an address that is a multiple of 8.
- R10: After the write to the all-ones address, the next write goes to address 0. wrapped_o is 1 from the write to the all-ones address until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Packing enable |
| sample_i | input | 16 | Sampled input levels |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 24 | Word address: row in [23:9], word in [8:0] |
| wr_data_o | output | 16 | Timestamp or sample word |
| wrapped_o | output | 1 | Sticky flag: address pointer has wrapped |

## Verification
The hardest conditions to reach from the ports are the forced cluster and the address wrap. The forced cluster needs the input held perfectly still with run high for a full 65536-tick window. The bench does exactly that once and checks that the second timestamp matches the first and lands exactly 65536 cycles later. For the wrap, the bench instance shrinks the row field to 2 bits and then toggles the input on every cycle. This packs clusters back to back until the pointer passes the top address. Stopping partway through a cluster is reached by dropping run two cycles after an opening edge, with a fresh value on each of those cycles, so the padded slots can be told apart from the earlier samples.

// File: rtl/pk_pkg.sv
// Package: shared types for the sample packer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pk_pkg;
    // Cluster engine state: waiting for a trigger, or emitting sample slots.
    typedef enum logic {
        PK_IDLE = 1'b0,
        PK_FILL = 1'b1
    } pk_state_e;
endpackage

// File: rtl/pk_tick_timer.sv
// Module: pk_tick_timer
// Runs the free-running timestamp counter and measures how long it has been
// since a cluster last opened. force_due_o is high once FORCE_TICKS edges
// have passed without an opening.
// Assumes FORCE_TICKS >= 2 and that open_i is a single-cycle pulse.
module pk_tick_timer #(
    parameter int TS_W        = 16,
    parameter int FORCE_TICKS = 65536
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            open_i,
    output logic [TS_W-1:0] tick_o,
    output logic            force_due_o
);
    localparam int                SINCE_W = $clog2(FORCE_TICKS) + 1;
    localparam logic [SINCE_W-1:0] LIMIT  = SINCE_W'(FORCE_TICKS - 1);

    logic [TS_W-1:0]    tick_q;
    logic [SINCE_W-1:0] since_q;

    // Free-running tick counter, one count per clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_q + 1'b1;
    end

    // Edges since the last cluster opened; saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_q <= '0;
        else if (open_i)          since_q <= '0;
        else if (since_q != LIMIT) since_q <= since_q + 1'b1;
    end

    assign tick_o      = tick_q;
    assign force_due_o = (since_q == LIMIT);

    // R6: a due force stays due until a cluster actually opens.
    a_r6_force_held: assert property (@(posedge clk) disable iff (!rst_n)
        force_due_o && !open_i |=> force_due_o);
    // R5: the counter advances by exactly one per edge.
    a_r5_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tick_o == TS_W'($past(tick_o) + 1'b1));
endmodule

// File: rtl/pk_addr_gen.sv
// Module: pk_addr_gen
// Linear word address pointer. Each advance registers the current pointer
// onto the write address and steps the pointer by one, wrapping from the
// all-ones address to 0 and setting a sticky wrap flag.
// Assumes adv_i is high for exactly the cycles that write a word.
module pk_addr_gen #(
    parameter int ROW_W = 15,
    parameter int COL_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv_i,
    output logic [ROW_W+COL_W-1:0] addr_o,
    output logic                   wrapped_o
);
    localparam int           AW  = ROW_W + COL_W;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] addr_q;
    logic          wrap_q;

    // Issue the pointer as the write address and step it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            addr_q <= '0;
        end else if (adv_i) begin
            addr_q <= ptr_q;
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    // Sticky wrap flag, set together with the write to the top address.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wrap_q <= 1'b0;
        else if (adv_i && ptr_q == TOP) wrap_q <= 1'b1;
    end

    assign addr_o    = addr_q;
    assign wrapped_o = wrap_q;

    // R10: the flag rises only as the top address is written.
    a_r10_wrap_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrapped_o) |-> addr_o == TOP);
    // R10: once set, the flag holds.
    a_r10_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped_o |=> wrapped_o);
endmodule

// File: rtl/pk_cluster_fsm.sv
// Module: pk_cluster_fsm
// Decides when a cluster opens (value change, forced interval, or fresh
// start) and emits the timestamp word followed by EVENTS sample words. The
// sample stream runs one stage behind the input, so the first slot carries
// the sample taken on the timestamp tick. After a stop, the held sample is
// frozen and repeated into the remaining slots.
// Assumes TS_W <= DATA_W; timestamps are zero-extended.
module pk_cluster_fsm
    import pk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TS_W   = 16,
    parameter int EVENTS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [TS_W-1:0]   tick_i,
    input  logic              force_due_i,
    output logic              open_o,
    output logic              adv_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int              SLOT_W = $clog2(EVENTS + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(EVENTS - 1);

    pk_state_e         st_q;
    logic [SLOT_W-1:0] slot_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] last_q;
    logic              pend_q;
    logic              wr_en_q;
    logic [DATA_W-1:0] wr_data_q;
    logic              changed;

    // Opening decision for this edge.
    always_comb begin
        changed = (sample_i != last_q);
        open_o  = (st_q == PK_IDLE) && run_i && (changed || force_due_i || pend_q);
        adv_o   = open_o || (st_q == PK_FILL);
    end

    // Start request: armed by any stopped edge, consumed by an opening.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b1;
        else if (!run_i) pend_q <= 1'b1;
        else if (open_o) pend_q <= 1'b0;
    end

    // Cluster engine: timestamp on opening, then the sample slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= PK_IDLE;
            slot_q    <= '0;
            hold_q    <= '0;
            last_q    <= '0;
            wr_data_q <= '0;
        end else begin
            case (st_q)
                PK_IDLE: begin
                    if (open_o) begin
                        wr_data_q <= DATA_W'(tick_i);
                        hold_q    <= sample_i;
                        slot_q    <= '0;
                        st_q      <= PK_FILL;
                    end
                end
                PK_FILL: begin
                    wr_data_q <= hold_q;
                    last_q    <= hold_q;
                    if (run_i) hold_q <= sample_i;
                    if (slot_q == LAST_SLOT) st_q <= PK_IDLE;
                    else                     slot_q <= slot_q + 1'b1;
                end
                default: st_q <= PK_IDLE;
            endcase
        end
    end

    // Write strobe follows the advance decision by one register.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_en_q <= 1'b0;
        else        wr_en_q <= adv_o;
    end

    assign wr_en_o   = wr_en_q;
    assign wr_data_o = wr_data_q;

    // R2: stopped and idle means no write on the next cycle.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PK_IDLE && !run_i |=> !wr_en_o);
    // R3: every fill cycle produces a write.
    a_r3_fill_writes: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PK_FILL |=> wr_en_o);
    // R6: a due force while idle and running opens with the current tick.
    a_r6_force_opens: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PK_IDLE && run_i && force_due_i |=>
        wr_en_o && wr_data_o == DATA_W'($past(tick_i)));
endmodule

// File: rtl/pk_sample_packer.sv
// Module: pk_sample_packer (top)
// Change-driven packer: clusters of one timestamp and EVENTS samples,
// written to consecutive word addresses split into row and word fields.
// Assumes EVENTS+1 is a power of two dividing the row size, so clusters
// never straddle a row.
module pk_sample_packer #(
    parameter int DATA_W      = 16,
    parameter int TS_W        = 16,
    parameter int ROW_W       = 15,
    parameter int COL_W       = 9,
    parameter int EVENTS      = 7,
    parameter int FORCE_TICKS = 65536
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_i,
    input  logic [DATA_W-1:0]      sample_i,
    output logic                   wr_en_o,
    output logic [ROW_W+COL_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0]      wr_data_o,
    output logic                   wrapped_o
);
    localparam int AW = ROW_W + COL_W;
    localparam int CL = EVENTS + 1;

    logic [TS_W-1:0] tick;
    logic            force_due;
    logic            open_cl;
    logic            adv;

    pk_tick_timer #(.TS_W(TS_W), .FORCE_TICKS(FORCE_TICKS)) timer_i (
        .clk(clk), .rst_n(rst_n), .open_i(open_cl),
        .tick_o(tick), .force_due_o(force_due)
    );

    pk_cluster_fsm #(.DATA_W(DATA_W), .TS_W(TS_W), .EVENTS(EVENTS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .sample_i(sample_i),
        .tick_i(tick), .force_due_i(force_due),
        .open_o(open_cl), .adv_o(adv),
        .wr_en_o(wr_en_o), .wr_data_o(wr_data_o)
    );

    pk_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) addr_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv),
        .addr_o(wr_addr_o), .wrapped_o(wrapped_o)
    );

    // R9: back-to-back writes step the address by one.
    a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && $past(wr_en_o) |-> wr_addr_o == AW'($past(wr_addr_o) + 1'b1));
    // R9: a write after a gap starts a cluster on a cluster boundary.
    a_r9_cluster_align: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && !$past(wr_en_o) |-> (int'(wr_addr_o) % CL) == 0);
endmodule

// File: tb/pk_sample_packer_tb.sv
`timescale 1ns/1ps
module pk_sample_packer_tb_top;
    localparam int ROW_W = 2;
    localparam int COL_W = 9;
    localparam int AW    = ROW_W + COL_W;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};
    localparam int FT    = 65536;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [15:0]   smp = 16'h0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;
    logic          wrapped;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pk_sample_packer #(.ROW_W(ROW_W), .COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .sample_i(smp),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wrapped_o(wrapped)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // Edge counter since reset release (equals the expected tick).
    int cyc = 0;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Reference stream built from the requirements.
    bit          m_busy, m_pend, e_en, m_op, m_live;
    int          m_slot, m_since;
    logic [15:0] m_hold, m_last, m_tick, e_data;
    logic [AW-1:0] m_ptr, e_addr;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_pend = 1; m_slot = 0; m_since = 0; m_hold = 0;
            m_last = 0; m_tick = 0; m_ptr = 0; e_en = 0; e_data = 0; e_addr = 0;
            m_live = 0;
        end else begin
            m_live = 1;
            m_op = 0;
            e_en = 0;
            if (m_busy) begin
                e_en = 1; e_data = m_hold; e_addr = m_ptr; m_ptr = m_ptr + 1'b1;
                m_last = m_hold;
                if (run) m_hold = smp;
                if (m_slot == 6) m_busy = 0; else m_slot++;
            end else if (run && (smp != m_last || m_since == FT - 1 || m_pend)) begin
                m_op = 1; e_en = 1; e_data = m_tick; e_addr = m_ptr; m_ptr = m_ptr + 1'b1;
                m_hold = smp; m_busy = 1; m_slot = 0;
            end
            if (!run) m_pend = 1; else if (m_op) m_pend = 0;
            if (m_op) m_since = 0; else if (m_since != FT - 1) m_since++;
            m_tick = m_tick + 1'b1;
        end
    end

    // Stream comparison and write monitor, away from the active edge.
    int          n_wr = 0, cl_count = 0, want_cl = -1;
    logic [15:0] clw [8];
    logic [15:0] snap [8];
    logic [15:0] ts_d = 0, ts_pd = 0;
    int          ts_c = 0, ts_pc = 0;
    bit          saw_wrap = 0, top_seen = 0;
    always @(negedge clk) begin
        if (rst_n && m_live) begin
            chk(wr_en == e_en, "R3 stream strobe", int'(wr_en), int'(e_en));
            if (e_en && wr_en) begin
                chk(wr_data == e_data, "R3 stream data", int'(wr_data), int'(e_data));
                chk(wr_addr == e_addr, "R9 stream address", int'(wr_addr), int'(e_addr));
            end
        end
        if (rst_n && wr_en) begin
            n_wr++;
            clw[wr_addr[2:0]] = wr_data;
            if (wr_addr[2:0] == 3'd0) begin
                ts_pd = ts_d; ts_pc = ts_c; ts_d = wr_data; ts_c = cyc - 1;
            end
            if (wr_addr[2:0] == 3'd7) begin
                cl_count++;
                if (cl_count == want_cl) for (int i = 0; i < 8; i++) snap[i] = clw[i];
            end
            if (top_seen && wr_addr == '0) saw_wrap = 1;
            if (wr_addr == TOP) begin
                top_seen = 1;
                chk(wrapped == 1'b1, "R10 flag at top write", int'(wrapped), 1);
            end else top_seen = 0;
        end
    end

    // Watchdog: a hung run counts as a failure.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", wd);
            finish_run();
        end
    end

    // Table: {value, expected writes during the step}; run stays high.
    localparam logic [23:0] TBL [8] = '{
        {16'h1234, 8'd8}, {16'h1234, 8'd0}, {16'hFFFF, 8'd8}, {16'h0000, 8'd8},
        {16'h0000, 8'd0}, {16'h8001, 8'd8}, {16'h8001, 8'd0}, {16'h0001, 8'd8}
    };

    initial begin
        int n0;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(wr_en == 1'b0, "R1 strobe after reset", int'(wr_en), 0);
        chk(wrapped == 1'b0, "R1 wrap after reset", int'(wrapped), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(wr_en == 1'b0, "R1 no write while stopped", int'(wr_en), 0);

        // R7/R5: start opens a cluster even for value 0; timestamp = tick
        n0 = n_wr;
        run = 1'b1; smp = 16'h0000;
        repeat (12) @(negedge clk);
        chk(n_wr - n0 == 8, "R7 start cluster writes", n_wr - n0, 8);
        chk(int'(ts_d) == (ts_c & 16'hFFFF), "R5 timestamp equals tick", int'(ts_d), ts_c & 16'hFFFF);
        chk(clw[1] == 16'h0000, "R3 start sample", int'(clw[1]), 0);

        // Table walk: R4 change/no-change, R3 first sample
        for (int k = 0; k < 8; k++) begin
            n0 = n_wr;
            smp = TBL[k][23:8];
            repeat (20) @(negedge clk);
            chk(n_wr - n0 == int'(TBL[k][7:0]), "R4 writes per step", n_wr - n0, int'(TBL[k][7:0]));
            if (TBL[k][7:0] != 0)
                chk(clw[1] == TBL[k][23:8], "R3 first sample", int'(clw[1]), int'(TBL[k][23:8]));
        end

        // R3: ramp, one new value per edge
        want_cl = cl_count + 1;
        for (int i = 0; i < 8; i++) begin
            smp = 16'h4000 + 16'(i);
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
        for (int i = 0; i < 7; i++)
            chk(snap[i+1] == 16'h4000 + 16'(i), "R3 ramp slot", int'(snap[i+1]), 16'h4000 + i);

        // R8: stop two edges into a cluster
        want_cl = cl_count + 1;
        smp = 16'hA5A5; @(negedge clk);
        smp = 16'h5A5A; @(negedge clk);
        run = 1'b0; smp = 16'h0F0F;
        repeat (12) @(negedge clk);
        chk(snap[1] == 16'hA5A5, "R8 slot before stop", int'(snap[1]), 16'hA5A5);
        for (int i = 2; i < 8; i++)
            chk(snap[i] == 16'h5A5A, "R8 padded slot", int'(snap[i]), 16'h5A5A);

        // R2: stopped and idle writes nothing
        n0 = n_wr;
        smp = 16'h1111;
        repeat (20) @(negedge clk);
        chk(n_wr == n0, "R2 quiet while stopped", n_wr - n0, 0);

        // R7: restart with the last stored value still opens a cluster
        n0 = n_wr;
        smp = 16'h5A5A; run = 1'b1;
        repeat (12) @(negedge clk);
        chk(n_wr - n0 == 8, "R7 restart cluster", n_wr - n0, 8);

        // R6: forced cluster after a full quiet window
        n0 = cl_count;
        smp = 16'h7E7E;
        repeat (FT + 30) @(negedge clk);
        chk(cl_count - n0 == 2, "R6 cluster count", cl_count - n0, 2);
        chk(ts_c - ts_pc == FT, "R6 forced spacing", ts_c - ts_pc, FT);
        chk(ts_d == ts_pd, "R6 repeated timestamp", int'(ts_d), int'(ts_pd));

        // R10: pack back to back until the pointer wraps
        chk(wrapped == 1'b0, "R10 no wrap yet", int'(wrapped), 0);
        v = 16'h0;
        for (int i = 0; i < 2200; i++) begin
            v = ~v;
            smp = v;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk(saw_wrap == 1'b1, "R10 address returns to 0", int'(saw_wrap), 1);
        chk(wrapped == 1'b1, "R10 flag sticky", int'(wrapped), 1);

        // R1: reset clears the flag and the strobe
        rst_n = 1'b0; run = 1'b0;
        repeat (2) @(negedge clk);
        chk(wrapped == 1'b0, "R1 wrap cleared by reset", int'(wrapped), 0);
        chk(wr_en == 1'b0, "R1 strobe cleared by reset", int'(wr_en), 0);
        finish_run();
    end
endmodule